// File: doc/BRIEF.md
# Triple-Redundant Push-Button Counter

This block is a small up-counter hardened against single register upsets. Three identical count registers hold the state. Each register feeds its own bitwise two-out-of-three voter. Each replica builds its next value from its own voted word and not from its raw register, so a register that has been hit is rewritten with the agreed value on the following edge. The three voted words leave the block as three separate output groups, one per redundancy domain, for example to drive three banks of indicator lights.

Two asynchronous push-button inputs drive the counter. The increment button passes through a two-stage synchronizer, and only the rising edge of the synchronized level is used, so one press advances the count once however long the button is held. The clear button is also synchronized, and it forces the count to zero for as long as it is seen high. The synchronizer is input conditioning and is shared by all three domains. A test-only upset mask for each replica flips chosen bits of that replica's register at a clock edge. A combinational disagreement flag reports any cycle in which the three raw registers differ.

Top module: `tmr_counter`

## Requirements
- R1: While `rst_n` is low, all three output groups read 0 and `disagree` is 0, regardless of the clock.
- R2: A rising edge on `btn_inc` that is set up before clock edge E1 changes the count at clock edge E3, not earlier, by exactly +1.
- R3: Holding `btn_inc` high for any number of cycles gives exactly one increment. Its release gives none.
- R4: An increment from 15 (all four bits set) gives 0, and counting then continues upward from 0.
- R5: `btn_clr` high before edge E1 forces the count to 0 at edge E3, and the count stays 0 for as long as the button stays high.
- R6: When the synchronized clear and an increment edge are present in the same cycle, the clear wins and the count becomes 0.
- R7: A nonzero mask on `upset_a`, `upset_b` or `upset_c` during a clock edge XORs that replica's register at that edge. While no bit is flipped in two replicas at once, the three output groups stay equal to each other and to the true count.
- R8: After an upset in a single replica, `disagree` is 1 for exactly the one cycle after the corrupting edge and returns to 0 at the next edge, with no further stimulus.
- R9: `disagree` is 0 in every cycle that follows a clock edge at which no upset mask was applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| btn_inc | input | 1 | Asynchronous increment button, active high |
| btn_clr | input | 1 | Asynchronous clear button, active high |
| upset_a | input | 4 | Test-only bit-flip mask for replica A |
| upset_b | input | 4 | Test-only bit-flip mask for replica B |
| upset_c | input | 4 | Test-only bit-flip mask for replica C |
| led_a | output | 4 | Voted count of domain A |
| led_b | output | 4 | Voted count of domain B |
| led_c | output | 4 | Voted count of domain C |
| disagree | output | 1 | High while the three raw registers do not all match |

## Verification
A button level driven before edge E1 reaches the synchronized stage at E2 and moves the count at E3. The bench drives inputs on falling edges and samples at the falling edge after E2 to see the old value and after E3 to see the new one. An upset mask acts at the very next edge. The disagreement flag is therefore checked one falling edge after the mask is applied, where it is expected high, and one falling edge later, where it is expected low. The output groups are compared with the bench's own count at every sample point. Random sequences of presses, clears, holds and upsets are run only after the button pipeline has settled, so each expected value depends on one operation alone.

// File: rtl/tmr_cnt_pkg.sv
package tmr_cnt_pkg;
  parameter int unsigned DOMAINS = 3;

  function automatic logic [31:0] maj3(input logic [31:0] a, input logic [31:0] b,
                                       input logic [31:0] c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/tmr_btn_cond.sv
module tmr_btn_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_inc,
  input  logic btn_clr,
  output logic inc_pulse,
  output logic clr_level
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] inc_sh_q, inc_sh_d;
  logic [SYNC_STAGES-1:0] clr_sh_q, clr_sh_d;
  logic                   inc_prev_q, inc_prev_d;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_comb begin
        inc_sh_d = {inc_sh_q[SYNC_STAGES-2:0], btn_inc};
        clr_sh_d = {clr_sh_q[SYNC_STAGES-2:0], btn_clr};
      end
    end else begin : g_single
      always_comb begin
        inc_sh_d = btn_inc;
        clr_sh_d = btn_clr;
      end
    end
  endgenerate

  always_comb inc_prev_d = inc_sh_q[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_sh_q   <= '0;
      clr_sh_q   <= '0;
      inc_prev_q <= 1'b0;
    end else begin
      inc_sh_q   <= inc_sh_d;
      clr_sh_q   <= clr_sh_d;
      inc_prev_q <= inc_prev_d;
    end
  end

  assign inc_pulse = inc_sh_q[LAST] & ~inc_prev_q;
  assign clr_level = clr_sh_q[LAST];

  // R3
  inc_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_pulse |=> !inc_pulse);
endmodule

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] c,
  output logic [WIDTH-1:0] y
);
  always_comb y = (a & b) | (a & c) | (b & c);

  // R7
  always_comb begin
    if (a == b) voter_pair_ab_chk: assert (y == a);
    if (b == c) voter_pair_bc_chk: assert (y == b);
  end
endmodule

// File: rtl/tmr_cnt_slice.sv
module tmr_cnt_slice #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  input  logic [WIDTH-1:0] voted,
  input  logic [WIDTH-1:0] upset,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_d;
  logic [WIDTH-1:0] base;

  always_comb begin
    if (clr)      base = '0;
    else if (inc) base = voted + WIDTH'(1);
    else          base = voted;
    q_d = base ^ upset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_cnt_pkg::*;
#(
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_inc,
  input  logic             btn_clr,
  input  logic [CNT_W-1:0] upset_a,
  input  logic [CNT_W-1:0] upset_b,
  input  logic [CNT_W-1:0] upset_c,
  output logic [CNT_W-1:0] led_a,
  output logic [CNT_W-1:0] led_b,
  output logic [CNT_W-1:0] led_c,
  output logic             disagree
);
  logic             inc_pulse, clr_level;
  logic [CNT_W-1:0] upset [DOMAINS];
  logic [CNT_W-1:0] q_raw [DOMAINS];
  logic [CNT_W-1:0] q_vote[DOMAINS];

  assign upset[0] = upset_a;
  assign upset[1] = upset_b;
  assign upset[2] = upset_c;

  tmr_btn_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .btn_inc   (btn_inc),
    .btn_clr   (btn_clr),
    .inc_pulse (inc_pulse),
    .clr_level (clr_level)
  );

  for (genvar d = 0; d < DOMAINS; d++) begin : g_dom
    tmr_cnt_slice #(.WIDTH(CNT_W)) u_slice (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (inc_pulse),
      .clr   (clr_level),
      .voted (q_vote[d]),
      .upset (upset[d]),
      .q     (q_raw[d])
    );
    tmr_voter #(.WIDTH(CNT_W)) u_vote (
      .a (q_raw[0]),
      .b (q_raw[1]),
      .c (q_raw[2]),
      .y (q_vote[d])
    );
  end

  assign led_a    = q_vote[0];
  assign led_b    = q_vote[1];
  assign led_c    = q_vote[2];
  assign disagree = (q_raw[0] != q_raw[1]) || (q_raw[1] != q_raw[2]);

  logic any_upset, overlap;
  assign any_upset = |{upset_a, upset_b, upset_c};
  assign overlap   = |((upset_a & upset_b) | (upset_a & upset_c) | (upset_b & upset_c));

  // R9
  agree_when_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_upset |=> !disagree);
  // R7
  groups_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !overlap |=> (led_a == led_b) && (led_b == led_c));
  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_pulse && !clr_level && !overlap) |=> led_a == CNT_W'($past(led_a) + 1'b1));
  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_level && !overlap) |=> led_a == '0);
  // R3
  hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_pulse && !clr_level && !overlap) |=> $stable(led_a));
endmodule

// File: tb/tmr_counter_tb.sv
module tmr_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       btn_inc, btn_clr;
  logic [3:0] upset_a, upset_b, upset_c;
  logic [3:0] led_a, led_b, led_c;
  logic       disagree;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_cnt = 0;

  always #4 clk = ~clk;

  tmr_counter u_dut (
    .clk(clk), .rst_n(rst_n), .btn_inc(btn_inc), .btn_clr(btn_clr),
    .upset_a(upset_a), .upset_b(upset_b), .upset_c(upset_c),
    .led_a(led_a), .led_b(led_b), .led_c(led_c), .disagree(disagree)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(led_a == 4'(exp_cnt), req, led_a, exp_cnt);
    chk(led_b == 4'(exp_cnt), req, led_b, exp_cnt);
    chk(led_c == 4'(exp_cnt), req, led_c, exp_cnt);
    chk(disagree == 1'b0, req, disagree, 0);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input int hold, input string req);
    btn_inc = 1'b1;
    cyc(hold);
    btn_inc = 1'b0;
    cyc(4);
    exp_cnt = (exp_cnt + 1) % 16;
    chk_all(req);
  endtask

  task automatic clear(input int hold);
    btn_clr = 1'b1;
    cyc(hold);
    btn_clr = 1'b0;
    cyc(4);
    exp_cnt = 0;
    chk_all("R5");
  endtask

  task automatic hit(input int dom, input logic [3:0] mask);
    case (dom)
      0: upset_a = mask;
      1: upset_b = mask;
      default: upset_c = mask;
    endcase
    cyc(1);
    upset_a = '0; upset_b = '0; upset_c = '0;
    chk(disagree == 1'b1, "R8", disagree, 1);
    chk(led_a == 4'(exp_cnt) && led_b == 4'(exp_cnt) && led_c == 4'(exp_cnt),
        "R7", {led_a, led_b, led_c}, exp_cnt);
    cyc(1);
    chk(disagree == 1'b0, "R8", disagree, 0);
    chk_all("R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; btn_inc = 1'b0; btn_clr = 1'b0;
    upset_a = '0; upset_b = '0; upset_c = '0;
    cyc(3);
    chk_all("R1");
    rst_n = 1'b1;
    cyc(2);
    chk_all("R9");

    // R2 latency: old value after E2, new value after E3
    btn_inc = 1'b1;
    cyc(2);
    chk(led_a == 4'(exp_cnt), "R2", led_a, exp_cnt);
    cyc(1);
    exp_cnt = exp_cnt + 1;
    chk_all("R2");
    // R3 long hold, still one step
    cyc(10);
    chk_all("R3");
    btn_inc = 1'b0;
    cyc(6);
    chk_all("R3");

    // R4 rollover
    for (int i = 0; i < 14; i++) press(1, "R2");
    chk(exp_cnt == 15, "R4", led_a, 15);
    press(2, "R4");
    press(1, "R4");

    // R5 latency and hold
    press(1, "R2");
    btn_clr = 1'b1;
    cyc(2);
    chk(led_a == 4'(exp_cnt), "R5", led_a, exp_cnt);
    cyc(1);
    exp_cnt = 0;
    chk_all("R5");
    cyc(8);
    chk_all("R5");
    btn_clr = 1'b0;
    cyc(4);

    // R6 clear and increment edge together
    press(1, "R2"); press(1, "R2");
    btn_inc = 1'b1; btn_clr = 1'b1;
    cyc(4);
    btn_inc = 1'b0; btn_clr = 1'b0;
    cyc(4);
    exp_cnt = 0;
    chk_all("R6");

    // R7/R8 directed upsets
    press(1, "R2"); press(1, "R2"); press(1, "R2");
    hit(0, 4'b0001);
    hit(1, 4'b1111);
    hit(2, 4'b1000);
    upset_a = 4'b0011; upset_b = 4'b1100;
    cyc(1);
    upset_a = '0; upset_b = '0;
    chk(disagree == 1'b1, "R8", disagree, 1);
    chk_all_equal_r7: chk(led_a == 4'(exp_cnt) && led_b == led_a && led_c == led_a,
                          "R7", led_a, exp_cnt);
    cyc(1);
    chk_all("R8");

    // Random mix
    for (int k = 0; k < 400; k++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 6)      press(1 + int'($urandom % 5), "R2");
      else if (op < 7) clear(1 + int'($urandom % 4));
      else if (op < 9) hit(int'($urandom % 3), 4'(1 + ($urandom % 15)));
      else begin
        cyc(1 + int'($urandom % 6));
        chk_all("R9");
      end
    end

    // R1 asynchronous reset mid-run
    press(1, "R2");
    #1 rst_n = 1'b0;
    #1;
    exp_cnt = 0;
    chk_all("R1");
    cyc(2);
    rst_n = 1'b1;
    cyc(2);
    chk_all("R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule